// File: doc/BRIEF.md
# Load and Register-Jump Execution Unit

This unit carries out two kinds of 32-bit I-format instructions for a small integer core. The first is the family of memory reads: the unit adds the base register to the sign-extended 12-bit offset, fetches one, two or four bytes from a byte-addressed data store, widens the result to 32 bits with sign or zero fill, and writes it to the destination register. The second is the register-indirect jump-and-link: the unit saves the address of the following instruction in the destination register and moves the program counter to the base register plus the offset, with the lowest bit forced to zero.

The unit holds the program counter, a 32-entry register file and the data store. The data store is loaded a byte at a time through a separate preload port. One adder forms both the load address and the jump target. A single decode of the 3-bit function field sets both the access width and the fill mode. Every instruction goes through three states. `ST_IDLE` waits for `instr_valid_i` and latches the instruction on the transition *accept* to `ST_CALC`. `ST_CALC` registers the sum of base and offset on the transition *compute* to `ST_COMMIT`. `ST_COMMIT` writes the register, updates the program counter and the illegal flag, then returns on *retire* to `ST_IDLE`.

Top module: `ldjmp_unit`

## Requirements
- R1: After reset `pc_o` is 0, `illegal_o` is 0 and every register reads as zero.
- R2: The load address is the base register rs1 (bits 19:15) plus the 12-bit offset in bits 31:20, sign-extended. Negative offsets therefore count downward from the base.
- R3: A load with function field 000 (bits 14:12) reads one byte and copies its bit 7 into bits 31:8 of the result.
- R4: A load with function field 100 reads one byte and fills bits 31:8 with zeros.
- R5: Function fields 001 (sign fill) and 101 (zero fill) read a halfword from two bytes. The byte at the lower address is the least significant.
- R6: Function field 010 reads a word from four consecutive bytes in little-endian order.
- R7: Any other load function field (011, 110, 111), a jump whose function field is not 000, or an opcode (bits 6:0) other than 0000011 or 1100111 is illegal. It raises `illegal_o` until the next retire, writes no register and advances the PC by 4.
- R8: Opcode 1100111 with function field 000 writes the old PC+4 to rd and sets the PC to (rs1 + offset) with bit 0 cleared. When rd equals rs1, the target still uses the old rs1 value.
- R9: A write aimed at register x0 is dropped, so x0 always reads as zero.
- R10: Every retired instruction other than a legal jump advances the PC by exactly 4.
- R11: An instruction is accepted only in `ST_IDLE`. Its effects appear at the third rising edge after acceptance begins, and `instr_valid_i` is ignored while an instruction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| instr_valid_i | input | 1 | Instruction offered this cycle |
| pc_o | output | 32 | Current program counter |
| preload_we_i | input | 1 | Data store byte write strobe |
| preload_addr_i | input | MEM_AW | Data store byte address |
| preload_data_i | input | 8 | Data store byte value |
| illegal_o | output | 1 | Last retired instruction was illegal |

## Verification
The assertions check several properties on every cycle: the state order, that the PC stays frozen outside `ST_COMMIT`, that it steps by 4 on each non-jump retire, that a jump target is even, that x0 stays zero, that the flag follows an illegal retire, and that an unsigned byte load writes zero in its upper bits. Other behaviour depends on data values, and only the bench scenarios can show it: the exact bytes picked for each width and their little-endian order, sign fill against zero fill, negative offsets, the link value, and the rd-equals-rs1 ordering. The bench reads registers back through legal jumps to x0, using a pair of offsets 0 and 1 to recover bit 0.

// File: rtl/ldj_pkg.sv
package ldj_pkg;
    localparam logic [6:0] OPC_LOAD = 7'b0000011;
    localparam logic [6:0] OPC_JREG = 7'b1100111;

    typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_COMMIT} ldj_state_e;
    typedef enum logic [1:0] {OP_LOAD, OP_JUMP, OP_BAD} ldj_kind_e;
    typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} ldj_size_e;

    typedef struct packed {
        ldj_kind_e   kind;
        ldj_size_e   size;
        logic        sext;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [31:0] imm;
    } ldj_dec_t;
endpackage

// File: rtl/ldj_decode.sv
module ldj_decode
    import ldj_pkg::*;
(
    input  logic [31:0] instr,
    output ldj_dec_t    dec
);
    logic [2:0] fn;
    logic [6:0] opc;

    assign fn  = instr[14:12];
    assign opc = instr[6:0];

    always_comb begin
        dec.rd   = instr[11:7];
        dec.rs1  = instr[19:15];
        dec.imm  = {{20{instr[31]}}, instr[31:20]};
        dec.sext = ~fn[2];
        dec.size = SZ_WORD;
        dec.kind = OP_BAD;
        if (opc == OPC_LOAD) begin
            unique case (fn)
                3'b000, 3'b100: begin dec.size = SZ_BYTE; dec.kind = OP_LOAD; end
                3'b001, 3'b101: begin dec.size = SZ_HALF; dec.kind = OP_LOAD; end
                3'b010:         begin dec.size = SZ_WORD; dec.kind = OP_LOAD; end
                default:        dec.kind = OP_BAD;
            endcase
        end else if (opc == OPC_JREG && fn == 3'b000) begin
            dec.kind = OP_JUMP;
        end
    end
endmodule

// File: rtl/ldj_regfile.sv
module ldj_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  raddr,
    output logic [XLEN-1:0] rdata,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata
);
    logic [XLEN-1:0] regs [NREG];
    logic            we_eff;

    assign we_eff = we && (waddr != '0);
    assign rdata  = regs[raddr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we_eff) begin
            regs[waddr] <= wdata;
        end
    end

    AST_X0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0); // R9
endmodule

// File: rtl/ldj_datamem.sv
module ldj_datamem #(
    parameter int MEM_BYTES = 256,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [7:0]    pre_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_word
);
    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (pre_we) mem[pre_addr] <= pre_data;
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [AW-1:0] lane_addr;
        assign lane_addr = rd_addr + AW'(g);
        assign rd_word[8*g +: 8] = mem[lane_addr];
    end
endmodule

// File: rtl/ldj_extend.sv
module ldj_extend
    import ldj_pkg::*;
(
    input  ldj_size_e   size,
    input  logic        sext,
    input  logic [31:0] raw,
    output logic [31:0] value
);
    logic fill;

    always_comb begin
        fill = 1'b0;
        unique case (size)
            SZ_BYTE: begin
                fill  = sext & raw[7];
                value = {{24{fill}}, raw[7:0]};
            end
            SZ_HALF: begin
                fill  = sext & raw[15];
                value = {{16{fill}}, raw[15:0]};
            end
            default: value = raw;
        endcase
    end
endmodule

// File: rtl/ldjmp_unit.sv
module ldjmp_unit
    import ldj_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int NREG      = 32,
    localparam int MEM_AW   = $clog2(MEM_BYTES),
    localparam int RAW      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic              instr_valid_i,
    output logic [31:0]       pc_o,
    input  logic              preload_we_i,
    input  logic [MEM_AW-1:0] preload_addr_i,
    input  logic [7:0]        preload_data_i,
    output logic              illegal_o
);
    ldj_state_e  state_q, state_d;
    ldj_dec_t    dec_now, dec_q;
    logic [31:0] pc_q, sum_q, base, mem_word, ld_value, wb_data, link;
    logic        illegal_q, rf_we;

    ldj_decode u_dec (.instr(instr_i), .dec(dec_now));

    ldj_regfile #(.XLEN(32), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .raddr(dec_q.rs1[RAW-1:0]), .rdata(base),
        .we(rf_we), .waddr(dec_q.rd[RAW-1:0]), .wdata(wb_data)
    );

    ldj_datamem #(.MEM_BYTES(MEM_BYTES)) u_mem (
        .clk(clk), .pre_we(preload_we_i), .pre_addr(preload_addr_i),
        .pre_data(preload_data_i), .rd_addr(sum_q[MEM_AW-1:0]), .rd_word(mem_word)
    );

    ldj_extend u_ext (.size(dec_q.size), .sext(dec_q.sext), .raw(mem_word), .value(ld_value));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, compute, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (instr_valid_i) state_d = ST_CALC;
            ST_CALC:   state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign link    = pc_q + 32'd4;
    assign rf_we   = (state_q == ST_COMMIT) && (dec_q.kind != OP_BAD);
    assign wb_data = (dec_q.kind == OP_JUMP) ? link : ld_value;

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q     <= '0;
            sum_q     <= '0;
            pc_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (instr_valid_i) dec_q <= dec_now;
                ST_CALC:   sum_q <= base + dec_q.imm;
                ST_COMMIT: begin
                    illegal_q <= (dec_q.kind == OP_BAD);
                    pc_q <= (dec_q.kind == OP_JUMP) ? {sum_q[31:1], 1'b0} : link;
                end
                default: ;
            endcase
        end
    end

    assign pc_o      = pc_q;
    assign illegal_o = illegal_q;

    AST_ACCEPT_TO_CALC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && instr_valid_i) |=> (state_q == ST_CALC)); // R11
    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_COMMIT) |=> $stable(pc_o)); // R11
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && dec_q.kind != OP_JUMP) |=> (pc_o == $past(pc_o) + 32'd4)); // R10
    AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && dec_q.kind == OP_JUMP) |=> (pc_o[0] == 1'b0)); // R8
    AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && dec_q.kind == OP_BAD) |=> illegal_o); // R7
    AST_UBYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && dec_q.kind == OP_LOAD && !dec_q.sext && dec_q.size == SZ_BYTE)
        |-> (wb_data[31:8] == 24'd0)); // R4
endmodule

// File: tb/ldjmp_unit_tb.sv
module ldjmp_unit_tb;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   instr = '0;
    logic          valid = 1'b0;
    logic [31:0]   pc;
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [7:0]    pre_data = '0;
    logic          illegal;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ldjmp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_valid_i(valid), .pc_o(pc),
        .preload_we_i(pre_we), .preload_addr_i(pre_addr), .preload_data_i(pre_data),
        .illegal_o(illegal)
    );

    function automatic logic [31:0] enc_ld(input logic [2:0] f3, input int rd, input int rs1, input int off);
        logic [11:0] im = 12'(off);
        return {im, 5'(rs1), f3, 5'(rd), 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_jr(input logic [2:0] f3, input int rd, input int rs1, input int off);
        logic [11:0] im = 12'(off);
        return {im, 5'(rs1), f3, 5'(rd), 7'b1100111};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = AW'(a); pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic poke_word(input int a, input logic [31:0] w);
        for (int i = 0; i < 4; i++) poke(a + i, w[8*i +: 8]);
    endtask

    task automatic issue(input logic [31:0] ins);
        @(negedge clk);
        instr = ins; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic probe(input int r, output logic [31:0] v);
        logic [31:0] a;
        issue(enc_jr(3'b000, 0, r, 0));
        a = pc;
        issue(enc_jr(3'b000, 0, r, 1));
        v = (pc == a) ? a : (a | 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 pc", pc, 32'd0);
        chk("R1 illegal", {31'd0, illegal}, 32'd0);
        probe(7, v);
        chk("R1 reg zero", v, 32'd0);
    endtask

    task automatic t_word;
        logic [31:0] p, v;
        p = pc;
        issue(enc_ld(3'b010, 9, 0, 'h10));
        chk("R10 pc step", pc, p + 4);
        chk("R7 legal flag low", {31'd0, illegal}, 32'd0);
        probe(9, v);
        chk("R6 word", v, 32'h8081F27F);
    endtask

    task automatic t_bytes;
        logic [31:0] v;
        issue(enc_ld(3'b000, 4, 0, 'h12)); probe(4, v);
        chk("R3 signed byte neg", v, 32'hFFFFFF81);
        issue(enc_ld(3'b000, 4, 0, 'h10)); probe(4, v);
        chk("R3 signed byte pos", v, 32'h0000007F);
        issue(enc_ld(3'b100, 5, 0, 'h12)); probe(5, v);
        chk("R4 unsigned byte", v, 32'h00000081);
    endtask

    task automatic t_half;
        logic [31:0] v;
        issue(enc_ld(3'b001, 6, 0, 'h12)); probe(6, v);
        chk("R5 signed half", v, 32'hFFFF8081);
        issue(enc_ld(3'b101, 7, 0, 'h12)); probe(7, v);
        chk("R5 unsigned half", v, 32'h00008081);
        issue(enc_ld(3'b001, 8, 0, 'h10)); probe(8, v);
        chk("R5 signed half low", v, 32'hFFFFF27F);
    endtask

    task automatic t_base;
        logic [31:0] v;
        issue(enc_ld(3'b010, 2, 0, 'h20)); probe(2, v);
        chk("R2 base load", v, 32'h00000020);
        issue(enc_ld(3'b000, 3, 2, -16)); probe(3, v);
        chk("R2 negative offset", v, 32'h0000007F);
        issue(enc_ld(3'b100, 12, 2, -15)); probe(12, v);
        chk("R2 offset lane", v, 32'h000000F2);
    endtask

    task automatic t_x0;
        logic [31:0] p, v;
        p = pc;
        issue(enc_ld(3'b010, 0, 0, 'h10));
        chk("R9 pc", pc, p + 4);
        probe(0, v);
        chk("R9 x0 zero", v, 32'd0);
    endtask

    task automatic t_illegal;
        logic [31:0] p, v;
        logic [31:0] bad [3];
        bad[0] = enc_ld(3'b011, 10, 0, 'h10);
        bad[1] = enc_jr(3'b010, 10, 2, 0);
        bad[2] = {12'h010, 5'd0, 3'b010, 5'd10, 7'b0010011};
        for (int k = 0; k < 3; k++) begin
            p = pc;
            issue(bad[k]);
            chk("R7 flag", {31'd0, illegal}, 32'd1);
            chk("R7 pc step", pc, p + 4);
            probe(10, v);
            chk("R7 no write", v, 32'd0);
            chk("R7 flag cleared", {31'd0, illegal}, 32'd0);
        end
    endtask

    task automatic t_jump;
        logic [31:0] p, v;
        p = pc;
        issue(enc_jr(3'b000, 11, 2, 5));
        chk("R8 target", pc, 32'h24);
        probe(11, v);
        chk("R8 link", v, p + 4);
        p = pc;
        issue(enc_jr(3'b000, 2, 2, -4));
        chk("R8 rd eq rs1 target", pc, 32'h1C);
        probe(2, v);
        chk("R8 rd eq rs1 link", v, p + 4);
    endtask

    task automatic t_timing;
        logic [31:0] p;
        p = pc;
        @(negedge clk);
        instr = enc_ld(3'b010, 0, 0, 'h10); valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 not yet", pc, p);
        @(negedge clk);
        valid = 1'b0;
        chk("R11 third edge", pc, p + 4);
        repeat (4) @(negedge clk);
        chk("R11 busy ignored", pc, p + 4);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        poke_word('h10, 32'h8081F27F);
        poke_word('h20, 32'h00000020);
        t_reset();
        t_word();
        t_bytes();
        t_half();
        t_base();
        t_x0();
        t_illegal();
        t_jump();
        t_timing();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule